// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one start request into the column addresses of a memory read or write burst, one address per clock beat. The requester gives a starting column, a burst length of 2, 4 or 8 beats and an ordering. The block then steps through every beat of an aligned block of columns. The low bits of the start column choose the first beat inside the block. The bits above the block stay fixed for the whole burst.

Two orderings are available. Sequential ordering counts upward from the start offset and wraps inside the block. Interleaved ordering forms each offset as the start offset XOR the beat number. The block runs one burst at a time. A start request that arrives while a burst is running is dropped.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and directly after it, `addr_vld_o`, `busy_o` and `last_o` are low.
- R2: A start seen with `busy_o` low is accepted. The first address appears in the next cycle and equals `start_col_i`. The burst then lasts 2, 4 or 8 consecutive valid cycles for `blen_i` codes 2'b00, 2'b01 and 2'b10. Code 2'b11 is treated as 8 beats.
- R3: With `btype_i` = 0 (sequential), the offset of beat k is (start offset + k) modulo the burst length. For example, start 5 with 8 beats gives 5,6,7,0,1,2,3,4.
- R4: With `btype_i` = 1 (interleaved), the offset of beat k is the start offset XOR k. For example, start 5 with 8 beats gives 5,4,7,6,1,0,3,2.
- R5: Every address of a burst keeps the start column's bits above the offset field: bit 0 for 2 beats, bits 1:0 for 4 beats, bits 2:0 for 8 beats. Wrapping never carries into the upper bits.
- R6: For a 2-beat burst, both orderings give the same sequence.
- R7: Length and ordering are captured at acceptance. Changes to `blen_i`, `btype_i` or `start_col_i` during a burst do not alter its addresses or its length.
- R8: `last_o` is high only with the final address of a burst, and `addr_vld_o` is also high in that cycle.
- R9: A start during a burst, including during its last beat, is ignored, and `busy_o` stays high until the final beat. In the cycle after the final beat `busy_o` is low and a start there is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | COL_W | Starting column address |
| blen_i | input | 2 | Length code: 00=2, 01=4, 10=8, 11=8 beats |
| btype_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| busy_o | output | 1 | A burst is running |
| addr_vld_o | output | 1 | `addr_o` holds a beat address |
| addr_o | output | COL_W | Column address of the current beat |
| last_o | output | 1 | Current beat is the final one |

## Verification
A wrong beat counter or a wrongly latched length shows up as a burst that is too short or too long. The bench sees this either as a missing or misplaced `last_o` or as a valid cycle where idle was expected, one cycle after the faulty beat. A corrupted ordering or offset register shows up at the very next beat, because every beat address is compared with a value the bench computes from the start column. A capture register that follows the inputs during a burst changes the addresses on the beat right after the input change. The bench provokes this on purpose by disturbing the inputs in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int OFF_W = 3;

  typedef enum logic [1:0] {
    BL_2  = 2'b00,
    BL_4  = 2'b01,
    BL_8  = 2'b10,
    BL_8X = 2'b11
  } blen_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } border_e;

  // In-block offset mask; also equals the index of the final beat.
  function automatic logic [OFF_W-1:0] len_mask(blen_e l);
    case (l)
      BL_2:    return 3'b001;
      BL_4:    return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  // Low address bits for a given beat; bits outside the mask are held.
  function automatic logic [OFF_W-1:0] beat_offset(
    logic [OFF_W-1:0] start_off,
    logic [OFF_W-1:0] beat,
    blen_e            l,
    border_e          o
  );
    logic [OFF_W-1:0] raw;
    logic [OFF_W-1:0] m;
    m   = len_mask(l);
    raw = (o == ORD_XOR) ? (start_off ^ beat) : (start_off + beat);
    return (raw & m) | (start_off & ~m);
  endfunction

endpackage

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  blen_e            blen_i,
  input  border_e          btype_i,
  output logic             active_o,
  output logic [OFF_W-1:0] beat_o,
  output blen_e            blen_q_o,
  output border_e          btype_q_o,
  output logic             accept_o,
  output logic             final_o
);

  logic             active_q;
  logic [OFF_W-1:0] beat_q;
  blen_e            blen_q;
  border_e          btype_q;

  assign accept_o  = start_i && !active_q;
  assign final_o   = active_q && (beat_q == len_mask(blen_q));
  assign active_o  = active_q;
  assign beat_o    = beat_q;
  assign blen_q_o  = blen_q;
  assign btype_q_o = btype_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      blen_q   <= BL_2;
      btype_q  <= ORD_SEQ;
    end else if (accept_o) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      blen_q   <= blen_i;
      btype_q  <= btype_i;
    end else if (final_o) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (active_q) begin
      beat_q   <= beat_q + 1'b1;
    end
  end

  // R2: beat index never passes the final beat of the latched length
  assert_beat_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (beat_q <= len_mask(blen_q)));

  // R9: a running, non-final burst advances by one beat regardless of start
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !final_o) |=> (active_q && beat_q == $past(beat_q) + 1'b1));

  // R9: the cycle after the final beat is idle
  assert_idle_after_final_R9: assert property (@(posedge clk) disable iff (!rst_n)
    final_o |=> !active_q);

  // R7: length and ordering hold through the burst
  assert_cfg_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !final_o) |=> ($stable(blen_q) && $stable(btype_q)));

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             step_i,
  input  logic             valid_i,
  input  logic [OFF_W-1:0] beat_i,
  input  blen_e            blen_i,
  input  border_e          btype_i,
  output logic [COL_W-1:0] addr_o
);

  localparam int UP_W = COL_W - OFF_W;

  logic [COL_W-1:0] col_q;
  logic [OFF_W-1:0] off_w;

  always_ff @(posedge clk) begin
    if (!rst_n)      col_q <= '0;
    else if (load_i) col_q <= col_i;
  end

  assign off_w  = beat_offset(col_q[OFF_W-1:0], beat_i, blen_i, btype_i);
  assign addr_o = {col_q[COL_W-1:OFF_W], off_w};

  // R5: bits above the offset field never change within a burst
  assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && $past(step_i)) |-> (addr_o[COL_W-1:OFF_W] == $past(addr_o[COL_W-1:OFF_W])));

  // R3: sequential ordering steps the masked offset by one
  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && $past(step_i) && btype_i == ORD_SEQ) |->
      ((addr_o[OFF_W-1:0] & len_mask(blen_i)) ==
       (($past(addr_o[OFF_W-1:0]) + 1'b1) & len_mask(blen_i))));

  // R4: interleaved ordering: consecutive offsets differ by beat ^ (beat-1)
  assert_xor_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && $past(step_i) && btype_i == ORD_XOR) |->
      ((addr_o[OFF_W-1:0] ^ $past(addr_o[OFF_W-1:0])) == (beat_i ^ (beat_i - 1'b1))));

  initial begin
    assert_width_ok: assert (UP_W >= 1);
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       blen_i,
  input  logic             btype_i,
  output logic             busy_o,
  output logic             addr_vld_o,
  output logic [COL_W-1:0] addr_o,
  output logic             last_o
);

  logic             active_w;
  logic             accept_w;
  logic             final_w;
  logic             step_w;
  logic [OFF_W-1:0] beat_w;
  blen_e            blen_q_w;
  border_e          btype_q_w;

  burst_beat_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .blen_i    (blen_e'(blen_i)),
    .btype_i   (border_e'(btype_i)),
    .active_o  (active_w),
    .beat_o    (beat_w),
    .blen_q_o  (blen_q_w),
    .btype_q_o (btype_q_w),
    .accept_o  (accept_w),
    .final_o   (final_w)
  );

  assign step_w = active_w && !final_w;

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept_w),
    .col_i   (start_col_i),
    .step_i  (step_w),
    .valid_i (active_w),
    .beat_i  (beat_w),
    .blen_i  (blen_q_w),
    .btype_i (btype_q_w),
    .addr_o  (addr_o)
  );

  assign busy_o     = active_w;
  assign addr_vld_o = active_w;
  assign last_o     = final_w;

  // R8: the final flag only accompanies a valid address
  assert_last_has_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> addr_vld_o);

  // R2: first beat repeats the accepted start column
  assert_first_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (addr_vld_o && addr_o == $past(start_col_i)));

  // R9: busy never drops without a final beat
  assert_busy_until_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(last_o));

endmodule

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [1:0]       blen_i = 2'b00;
  logic             btype_i = 1'b0;
  logic             busy_o, addr_vld_o, last_o;
  logic [COL_W-1:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .btype_i(btype_i), .busy_o(busy_o),
    .addr_vld_o(addr_vld_o), .addr_o(addr_o), .last_o(last_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int beats_of(int code);
    return (code == 0) ? 2 : (code == 1) ? 4 : 8;
  endfunction

  function automatic int exp_addr(int col, int n, int typ, int k);
    int blk = col - (col % n);
    int off = col % n;
    return typ ? blk + (off ^ k) : blk + ((off + k) % n);
  endfunction

  // Called at a negedge with the block idle; returns at the negedge after the last beat.
  task automatic run_burst(string req, int col, int code, int typ, bit disturb);
    int n = beats_of(code);
    start_i = 1'b1; start_col_i = col[COL_W-1:0]; blen_i = code[1:0]; btype_i = typ[0];
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      check({req, " valid"}, addr_vld_o, 1);
      check({req, " busy R9"}, busy_o, 1);
      check({req, " addr"}, addr_o, exp_addr(col, n, typ, k));
      check({req, " last R8"}, last_o, (k == n - 1));
      if (disturb) begin
        start_i = 1'b1; start_col_i = ~col[COL_W-1:0];
        blen_i = 2'b00; btype_i = ~typ[0];
      end
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  task automatic expect_idle(string req);
    check({req, " idle valid"}, addr_vld_o, 0);
    check({req, " idle busy"}, busy_o, 0);
    check({req, " idle last"}, last_o, 0);
  endtask

  task automatic t_reset;
    @(negedge clk); expect_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk); expect_idle("R1 after reset");
  endtask

  task automatic t_seq8;
    run_burst("R3 seq8 start5", 5, 2, 0, 0); expect_idle("R2 seq8 length");
  endtask

  task automatic t_xor8;
    run_burst("R4 xor8 start5", 5, 2, 1, 0); expect_idle("R2 xor8 length");
  endtask

  task automatic t_len4_all;
    for (int s = 0; s < 4; s++) begin
      run_burst("R3 seq4", 32'h40 + s, 1, 0, 0); expect_idle("R2 seq4");
      run_burst("R4 xor4", 32'h40 + s, 1, 1, 0); expect_idle("R2 xor4");
    end
  endtask

  task automatic t_len2;
    run_burst("R6 len2 seq", 9'h0F3, 0, 0, 0); expect_idle("R6 len2 seq end");
    run_burst("R6 len2 xor", 9'h0F3, 0, 1, 0); expect_idle("R6 len2 xor end");
  endtask

  task automatic t_top_wrap;
    run_burst("R5 wrap top seq", 10'h3FD, 2, 0, 0); expect_idle("R5 wrap end");
    run_burst("R5 wrap top xor", 10'h3FE, 1, 1, 0); expect_idle("R5 wrap xor end");
  endtask

  task automatic t_code3;
    run_burst("R2 code11 as 8", 10'h122, 3, 0, 0); expect_idle("R2 code11 end");
  endtask

  task automatic t_disturb;
    run_burst("R7 R9 disturbed", 10'h2B6, 2, 1, 1); expect_idle("R9 start on last ignored");
    run_burst("R7 disturbed seq4", 10'h0C9, 1, 0, 1); expect_idle("R9 disturbed seq4 end");
  endtask

  task automatic t_back_to_back;
    run_burst("R9 b2b first", 10'h011, 1, 0, 0);
    run_burst("R9 b2b second", 10'h1F7, 2, 1, 0);
    expect_idle("R9 b2b end");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_seq8();
    t_xor8();
    t_len4_all();
    t_len2();
    t_top_wrap();
    t_code3();
    t_disturb();
    t_back_to_back();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule